// File: doc/BRIEF.md
# RMII to MII Data Adapter

This block sits between a PHY core that moves data four bits at a time and a MAC that uses the reduced two-bit media-independent interface. Both sides share one 50 MHz reference clock. On the transmit side it collects pairs of di-bits from the MAC into nibbles and hands each finished nibble to the core with a one-cycle strobe. On the receive side it buffers the core's nibbles in a small queue and sends each one out as two di-bits. It also drives the combined carrier-sense/data-valid line and replaces the data of errored nibbles with a fixed pattern.

The `speed_100_i` input selects the rate. When it is high, every reference clock carries one di-bit. When it is low (10 Mb/s), one di-bit covers ten reference clocks: on transmit the adapter takes a single di-bit per ten-clock window, and on receive it holds each di-bit for ten clocks. The core marks each nibble with `mii_rx_valid_i` and reports carrier separately on `mii_crs_i`. This allows carrier to drop while nibbles are still queued, which exercises the end-of-frame toggling of the carrier/valid line.

Top module: `rmii_mii_adapter`

## Requirements
- R1: While reset is held and right after it, mii_tx_valid_o, rmii_crs_dv_o, rmii_rx_er_o and rmii_rxd_o are all 0.
- R2: At 100 Mb/s, every clock with rmii_tx_en_i high samples one di-bit. Two consecutive samples form a nibble: the first di-bit goes to bits 1:0 and the second to bits 3:2. The nibble appears on mii_txd_o with mii_tx_valid_o high for one cycle after the edge that sampled the second di-bit.
- R3: At 10 Mb/s, the adapter samples one di-bit on the first clock that rmii_tx_en_i is high and then every tenth clock while it stays high. Nibbles are formed as in R2.
- R4: Values on rmii_txd_i while rmii_tx_en_i is low produce no nibble. A single di-bit left unpaired when rmii_tx_en_i falls is discarded.
- R5: On receive, the low di-bit (bits 1:0) of each nibble is sent before bits 3:2. A nibble strobed into an empty adapter at edge t appears from edge t+1. Nibbles that arrive at the line rate go out back-to-back with no gap.
- R6: At 10 Mb/s, each receive di-bit is held on rmii_rxd_o for 10 consecutive clocks. At 100 Mb/s, each is held for 1 clock.
- R7: At 100 Mb/s, a nibble strobed with mii_rx_er_i high is sent as the di-bits 01, 01, and rmii_rx_er_o is high while they are sent.
- R8: At 10 Mb/s, rmii_rx_er_o stays low and errored nibbles pass through with their data unchanged.
- R9: rmii_crs_dv_o rises one clock after mii_crs_i is seen high, before any data. rmii_rxd_o is 00 whenever no di-bit is being sent.
- R10: While mii_crs_i is low and queued data remains, rmii_crs_dv_o is high during each low di-bit and low during each high di-bit. Once the queue drains, rmii_crs_dv_o and rmii_rxd_o return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 50 MHz reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| speed_100_i | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| rmii_tx_en_i | input | 1 | MAC transmit enable |
| rmii_txd_i | input | 2 | MAC transmit di-bit |
| mii_txd_o | output | 4 | Assembled transmit nibble |
| mii_tx_valid_o | output | 1 | One-cycle strobe for mii_txd_o |
| mii_rxd_i | input | 4 | Receive nibble from core |
| mii_rx_valid_i | input | 1 | One-cycle strobe for mii_rxd_i |
| mii_rx_er_i | input | 1 | Symbol error flag for the strobed nibble |
| mii_crs_i | input | 1 | Carrier sense from core |
| rmii_crs_dv_o | output | 1 | Carrier sense / data valid to MAC |
| rmii_rxd_o | output | 2 | Receive di-bit to MAC |
| rmii_rx_er_o | output | 1 | Receive error to MAC |

## Verification
A wrong slot counter or half-nibble flag shows up on the ports straight away. It produces transmit nibbles with their halves swapped or missing, or receive di-bits that are held too long or too short, and these appear within one di-bit window (one or ten clocks). Faults in queue ordering or error substitution appear on the very next di-bit sent. A fault in the end-of-frame carrier logic shows on rmii_crs_dv_o during the last nibbles after carrier drops. The bench therefore compares every clock of each receive frame and every transmit nibble against values predicted from the requirements.

// File: rtl/rmii_adapter_pkg.sv
package rmii_adapter_pkg;
  typedef struct packed {
    logic       err;
    logic [3:0] nib;
  } rx_entry_t;
endpackage

// File: rtl/rmii_tx_assembler.sv
module rmii_tx_assembler #(
  parameter int unsigned SLOT_10M = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       speed_100_i,
  input  logic       tx_en_i,
  input  logic [1:0] txd_i,
  output logic [3:0] nib_o,
  output logic       nib_valid_o
);
  localparam int unsigned CW = $clog2(SLOT_10M);

  logic [CW-1:0] cnt_q;
  logic          half_q;
  logic [1:0]    low_q;
  logic          take;

  assign take = tx_en_i && (speed_100_i || cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      half_q      <= 1'b0;
      low_q       <= '0;
      nib_o       <= '0;
      nib_valid_o <= 1'b0;
    end else begin
      nib_valid_o <= 1'b0;
      if (!tx_en_i) begin
        cnt_q  <= '0;
        half_q <= 1'b0;
      end else begin
        cnt_q <= (cnt_q == CW'(SLOT_10M - 1)) ? '0 : cnt_q + 1'b1;
      end
      if (take) begin
        if (!half_q) begin
          low_q  <= txd_i;
          half_q <= 1'b1;
        end else begin
          nib_o       <= {txd_i, low_q};
          nib_valid_o <= 1'b1;
          half_q      <= 1'b0;
        end
      end
    end
  end

  AST_TX_STROBE_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nib_valid_o |-> ($past(tx_en_i) && $past(rst_ni))); // R4
endmodule

// File: rtl/rmii_rx_fifo.sv
module rmii_rx_fifo
  import rmii_adapter_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      push_i,
  input  rx_entry_t entry_i,
  input  logic      pop_i,
  output rx_entry_t entry_o,
  output logic      empty_o
);
  localparam int unsigned AW = $clog2(DEPTH);

  rx_entry_t   mem_q [DEPTH];
  logic [AW:0] wr_q, rd_q;
  logic        full;

  assign empty_o = (wr_q == rd_q);
  assign full    = (wr_q[AW-1:0] == rd_q[AW-1:0]) && (wr_q[AW] != rd_q[AW]);
  assign entry_o = mem_q[rd_q[AW-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0;
      rd_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (push_i && !full) begin
        mem_q[wr_q[AW-1:0]] <= entry_i;
        wr_q                <= wr_q + 1'b1;
      end
      if (pop_i && !empty_o) rd_q <= rd_q + 1'b1;
    end
  end

  AST_NO_POP_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o); // R5
endmodule

// File: rtl/rmii_rx_serializer.sv
module rmii_rx_serializer
  import rmii_adapter_pkg::*;
#(
  parameter int unsigned SLOT_10M = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       speed_100_i,
  input  logic       empty_i,
  input  rx_entry_t  entry_i,
  output logic       pop_o,
  output logic       busy_o,
  output logic       phase_hi_o,
  output logic [1:0] rxd_o,
  output logic       rx_er_o
);
  localparam int unsigned CW = $clog2(SLOT_10M);

  logic [CW-1:0] cnt_q;
  logic          busy_q, phase_q, err_q;
  logic [3:0]    nib_q;
  logic          last_slot;

  assign last_slot = speed_100_i || (cnt_q == CW'(SLOT_10M - 1));
  assign pop_o     = (!busy_q || (last_slot && phase_q)) && !empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      err_q   <= 1'b0;
      nib_q   <= '0;
    end else if (pop_o) begin
      busy_q  <= 1'b1;
      phase_q <= 1'b0;
      cnt_q   <= '0;
      nib_q   <= entry_i.nib;
      err_q   <= entry_i.err && speed_100_i;  // errors only flagged at 100 Mb/s
    end else if (busy_q) begin
      if (last_slot) begin
        cnt_q <= '0;
        if (phase_q) busy_q  <= 1'b0;
        else         phase_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o     = busy_q;
  assign phase_hi_o = phase_q;
  assign rx_er_o    = busy_q && err_q;
  always_comb begin
    if (!busy_q)     rxd_o = 2'b00;
    else if (err_q)  rxd_o = 2'b01;
    else if (phase_q) rxd_o = nib_q[3:2];
    else             rxd_o = nib_q[1:0];
  end

  AST_SLOT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q != '0) |-> $stable(rxd_o)); // R6
  AST_ERR_PATTERN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_er_o |-> (rxd_o == 2'b01)); // R7
endmodule

// File: rtl/rmii_mii_adapter.sv
module rmii_mii_adapter
  import rmii_adapter_pkg::*;
#(
  parameter int unsigned SLOT_10M   = 10,
  parameter int unsigned FIFO_DEPTH = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       speed_100_i,
  input  logic       rmii_tx_en_i,
  input  logic [1:0] rmii_txd_i,
  output logic [3:0] mii_txd_o,
  output logic       mii_tx_valid_o,
  input  logic [3:0] mii_rxd_i,
  input  logic       mii_rx_valid_i,
  input  logic       mii_rx_er_i,
  input  logic       mii_crs_i,
  output logic       rmii_crs_dv_o,
  output logic [1:0] rmii_rxd_o,
  output logic       rmii_rx_er_o
);
  rx_entry_t wr_entry, rd_entry;
  logic      fifo_empty, pop, busy, phase_hi, crs_q;

  rmii_tx_assembler #(.SLOT_10M(SLOT_10M)) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .speed_100_i (speed_100_i),
    .tx_en_i     (rmii_tx_en_i),
    .txd_i       (rmii_txd_i),
    .nib_o       (mii_txd_o),
    .nib_valid_o (mii_tx_valid_o)
  );

  assign wr_entry.err = mii_rx_er_i;
  assign wr_entry.nib = mii_rxd_i;

  rmii_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (mii_rx_valid_i),
    .entry_i (wr_entry),
    .pop_i   (pop),
    .entry_o (rd_entry),
    .empty_o (fifo_empty)
  );

  rmii_rx_serializer #(.SLOT_10M(SLOT_10M)) u_ser (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .speed_100_i (speed_100_i),
    .empty_i     (fifo_empty),
    .entry_i     (rd_entry),
    .pop_o       (pop),
    .busy_o      (busy),
    .phase_hi_o  (phase_hi),
    .rxd_o       (rmii_rxd_o),
    .rx_er_o     (rmii_rx_er_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) crs_q <= 1'b0;
    else         crs_q <= mii_crs_i;
  end

  // after carrier loss, valid follows the low di-bit of each queued nibble
  assign rmii_crs_dv_o = crs_q || (busy && !phase_hi);

  AST_CRSDV_ON_CARRIER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mii_crs_i) && $past(rst_ni)) |-> rmii_crs_dv_o); // R9
endmodule

// File: tb/sim_rmii_mii_adapter.sv
module sim_rmii_mii_adapter;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       speed_100_i = 1'b1;
  logic       rmii_tx_en_i = 1'b0;
  logic [1:0] rmii_txd_i = '0;
  logic [3:0] mii_txd_o;
  logic       mii_tx_valid_o;
  logic [3:0] mii_rxd_i = '0;
  logic       mii_rx_valid_i = 1'b0;
  logic       mii_rx_er_i = 1'b0;
  logic       mii_crs_i = 1'b0;
  logic       rmii_crs_dv_o;
  logic [1:0] rmii_rxd_o;
  logic       rmii_rx_er_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [3:0] tx_q[$];

  always #4 clk_i = ~clk_i;

  rmii_mii_adapter u0 (.*);

  always @(negedge clk_i) if (mii_tx_valid_o) tx_q.push_back(mii_txd_o);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] exp_dibit(input logic [3:0] nib, input logic err,
                                           input bit sp100, input bit hi);
    if (err && sp100) return 2'b01;
    return hi ? nib[3:2] : nib[1:0];
  endfunction

  task automatic run_tx(input bit sp100, input int n);
    int slot = sp100 ? 1 : 10;
    logic [1:0] d[$];
    speed_100_i = sp100;
    tx_q.delete();
    for (int i = 0; i < n; i++) begin
      logic [1:0] v = 2'($urandom);
      d.push_back(v);
      rmii_tx_en_i = 1'b1;
      rmii_txd_i   = v;
      repeat (slot) @(negedge clk_i);
    end
    rmii_tx_en_i = 1'b0;
    for (int i = 0; i < 25; i++) begin
      rmii_txd_i = 2'($urandom);  // noise while disabled, R4
      @(negedge clk_i);
    end
    check("R4 nibble count", tx_q.size(), n / 2);
    for (int k = 0; k < n / 2 && k < tx_q.size(); k++)
      check(sp100 ? "R2 tx nibble" : "R3 tx nibble", tx_q[k], {d[2*k+1], d[2*k]});
  endtask

  task automatic run_rx(input bit sp100, input int n, input int err_pct);
    int slot = sp100 ? 1 : 10;
    int drop = 1 + (2*n - 4) * slot;
    int total = 2*n*slot + 3;
    logic [3:0] nib[$];
    logic       er[$];
    speed_100_i = sp100;
    for (int k = 0; k < n; k++) begin
      nib.push_back(4'($urandom));
      er.push_back(($urandom % 100) < err_pct);
    end
    for (int c = 0; c <= total; c++) begin
      int j;
      bit act, hi, crs_exp;
      logic [1:0] dexp;
      logic eexp;
      mii_crs_i      = (c < drop);
      mii_rx_valid_i = (c % (2*slot) == 0) && (c / (2*slot) < n);
      if (mii_rx_valid_i) begin
        mii_rxd_i   = nib[c/(2*slot)];
        mii_rx_er_i = er[c/(2*slot)];
      end else begin
        mii_rxd_i   = 4'($urandom);
        mii_rx_er_i = 1'($urandom);
      end
      @(negedge clk_i);
      j   = (c >= 1) ? (c - 1) / slot : 0;
      act = (c >= 1) && (j < 2*n);
      hi  = j[0];
      dexp = act ? exp_dibit(nib[j/2], er[j/2], sp100, hi) : 2'b00;
      eexp = act && er[j/2] && sp100;
      crs_exp = (c < drop) ? 1'b1 : (act && !hi);
      check(sp100 ? "R5 rxd" : "R6 rxd", rmii_rxd_o, dexp);
      check(sp100 ? "R7 rx_er" : "R8 rx_er", rmii_rx_er_o, eexp);
      check(c < drop ? "R9 crs_dv" : "R10 crs_dv", rmii_crs_dv_o, crs_exp);
    end
    mii_rx_valid_i = 1'b0;
    mii_crs_i      = 1'b0;
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    void'($urandom(32'h5eed_2024));
    repeat (3) @(negedge clk_i);
    check("R1 tx_valid", mii_tx_valid_o, 0);
    check("R1 crs_dv", rmii_crs_dv_o, 0);
    check("R1 rxd", rmii_rxd_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 rx_er", rmii_rx_er_o, 0);
    check("R1 crs_dv after", rmii_crs_dv_o, 0);

    run_tx(1'b1, 16);
    run_tx(1'b1, 7);        // odd count, R4
    run_tx(1'b0, 8);
    run_tx(1'b0, 5);        // odd count at 10 Mb/s, R4
    run_rx(1'b1, 6, 0);
    run_rx(1'b1, 8, 100);   // all errored, R7
    run_rx(1'b0, 4, 100);   // errors ignored, R8
    run_rx(1'b0, 5, 0);
    for (int i = 0; i < 6; i++) begin
      bit sp = 1'($urandom);
      run_tx(sp, 2 + int'($urandom % 12));
      run_rx(sp, 3 + int'($urandom % 6), 40);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule